// File: doc/BRIEF.md
# USB Endpoint Handshake Controller

This block keeps the control and status byte of one USB function endpoint and chooses the handshake for each token that the serial engine presents. A CPU reads and writes the byte through a simple register port. The serial engine presents a token with its type. In that same cycle the block returns its handshake choice: none, ACK, NAK or STALL. When the transaction finishes, the engine pulses a completion strobe together with a packet-good flag.

The status bits follow a write-zero-to-clear discipline, and hardware events take priority over CPU writes. For an IN endpoint, the CPU arms the buffer and the hardware disarms it after a good transfer. For an OUT endpoint, the hardware marks the buffer full and the CPU frees it. While either condition is pending, the endpoint answers NAK and the buffer is left untouched.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset the status byte reads 0x00, hs_code is 0 (none) and buf_wen is 0.
- R2: Bits 7:6 (mode), 5 (stall), 4 (dir, 1 = IN, 0 = OUT) and 3:2 (size) take the written value and read back unchanged.
- R3: Bit 0 (done flag) is set by a completion with pkt_good=1 of an accepted transaction. A CPU write with bit 0 = 0 clears it, and a write with bit 0 = 1 leaves it as it was.
- R4: While the done flag is 1, every token whose direction matches dir gets NAK (hs_code=2) unless stall is set.
- R5: With dir=IN, bit 1 (valid flag) takes the written value, and an IN token (tok_pid=1) gets NAK while the valid flag is 0.
- R6: With dir=IN, a completion with pkt_good=1 of an accepted IN transaction clears the valid flag.
- R7: With dir=OUT, a completion with pkt_good=1 of an accepted OUT transaction sets the valid flag. While the flag is 1, OUT tokens get NAK. A write with bit 1 = 1 has no effect, and a write with bit 1 = 0 clears it.
- R8: With stall=1, every direction-matching token gets STALL (hs_code=3), and no status bit changes.
- R9: OUT (tok_pid=0) and SETUP (tok_pid=2) tokens have OUT direction, and IN (tok_pid=1) has IN direction. A token whose direction differs from dir, or with tok_pid=3, gets hs_code=0 and changes nothing.
- R10: When a hardware update of the done or valid flag falls in the same cycle as a CPU write to that bit, the hardware value wins.
- R11: buf_wen rises in the cycle after an OUT-direction token gets ACK (hs_code=1) and falls after the next completion strobe. A token answered NAK or STALL never raises it.
- R12: A completion with pkt_good=0 ends the transaction and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | CPU write strobe for the status byte |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Current status byte |
| tok_valid | input | 1 | Token present this cycle |
| tok_pid | input | 2 | Token type: 0 OUT, 1 IN, 2 SETUP, 3 ignored |
| xfer_done | input | 1 | Transaction completion strobe |
| pkt_good | input | 1 | Transfer was good, qualifies xfer_done |
| hs_code | output | 2 | Handshake: 0 none, 1 ACK, 2 NAK, 3 STALL |
| buf_wen | output | 1 | Receive buffer write enable |

## Verification
The embedded properties check the following on every cycle: STALL and NAK priorities for matching tokens, that writing one never sets the done flag, that a good completion always leaves the done flag set, that IN completions disarm the buffer, and that a refused token cannot raise the buffer enable. Some behaviour is visible only across a sequence, so the bench scenarios cover it: full OUT and IN transfers, the read-back of configuration bits, the different effect of writing the valid flag in each direction, and failed packets that leave the status untouched. The bench also covers a mismatched token and a CPU clear that collides with a completion.

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tok_valid,
  input  logic [1:0] tok_pid,
  input  logic       xfer_done,
  input  logic       pkt_good,
  output logic [1:0] hs_code,
  output logic       buf_wen
);
  localparam logic [1:0] HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3;

  logic [1:0] mode, size;
  logic       stall, dir_in, valid, done;
  logic       busy, busy_in;

  assign reg_rdata = {mode, stall, dir_in, size, valid, done};

  logic tok_is_in, tok_is_out, match, refuse;
  assign tok_is_in  = tok_pid == 2'd1;
  assign tok_is_out = tok_pid == 2'd0 || tok_pid == 2'd2;
  assign match      = tok_valid && (dir_in ? tok_is_in : tok_is_out);
  assign refuse     = done || (dir_in ? !valid : valid);

  always_comb begin
    hs_code = HS_NONE;
    if (match) begin
      if (stall)       hs_code = HS_STALL;
      else if (refuse) hs_code = HS_NAK;
      else             hs_code = HS_ACK;
    end
  end

  logic finish_ok;
  assign finish_ok = xfer_done && busy && pkt_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {mode, stall, dir_in, size, valid, done} <= 8'h00;
      busy    <= 1'b0;
      busy_in <= 1'b0;
      buf_wen <= 1'b0;
    end else begin
      if (reg_wr) begin
        mode   <= reg_wdata[7:6];
        stall  <= reg_wdata[5];
        dir_in <= reg_wdata[4];
        size   <= reg_wdata[3:2];
        if (dir_in)          valid <= reg_wdata[1];
        else if (!reg_wdata[1]) valid <= 1'b0;
        if (!reg_wdata[0])   done  <= 1'b0;
      end
      if (xfer_done) begin
        busy    <= 1'b0;
        buf_wen <= 1'b0;
      end else if (hs_code == HS_ACK) begin
        busy    <= 1'b1;
        busy_in <= dir_in;
        buf_wen <= !dir_in;
      end
      if (finish_ok) begin
        done  <= 1'b1;
        valid <= !busy_in;
      end
    end
  end

  a_r8_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
    match && stall |-> hs_code == HS_STALL);

  a_r4_done_naks: assert property (@(posedge clk) disable iff (!rst_n)
    match && !stall && done |-> hs_code == HS_NAK);

  a_r3_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[0] && !done && !finish_ok |=> !done);

  a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ok |=> done);

  a_r6_in_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ok && busy_in |=> !valid);

  a_r11_no_wen_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_code == HS_NAK || hs_code == HS_STALL) && !buf_wen |=> !buf_wen);

  a_r9_no_reply_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    !match |-> hs_code == HS_NONE);
endmodule

// File: tb/test_usb_ep_handshake.sv
module test_usb_ep_handshake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       tok_valid = 1'b0;
  logic [1:0] tok_pid = 2'd0;
  logic       xfer_done = 1'b0;
  logic       pkt_good = 1'b0;
  logic [1:0] hs_code;
  logic       buf_wen;

  int compared = 0;
  int mismatched = 0;

  usb_ep_handshake i_usb_ep_handshake (.*);

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic tok(input logic [1:0] pid, input int exp_hs, input string tag);
    @(negedge clk); tok_valid = 1'b1; tok_pid = pid;
    #2 chk(tag, hs_code, exp_hs);
    @(negedge clk); tok_valid = 1'b0;
  endtask

  task automatic fin(input logic good);
    @(negedge clk); xfer_done = 1'b1; pkt_good = good;
    @(negedge clk); xfer_done = 1'b0; pkt_good = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk("R1 status", reg_rdata, 8'h00);
    chk("R1 hs", hs_code, 0);
    chk("R1 wen", buf_wen, 0);
  endtask

  task automatic t_config;
    cpu_wr(8'hCC); #1 chk("R2 readback", reg_rdata, 8'hCC);
    cpu_wr(8'h00); #1 chk("R2 clear", reg_rdata, 8'h00);
  endtask

  task automatic t_out_flow;
    tok(2'd0, 1, "R11 out ack");
    #1 chk("R11 wen high", buf_wen, 1);
    fin(1'b1);
    #1 chk("R11 wen low", buf_wen, 0);
    chk("R7 out set", reg_rdata, 8'h03);
    tok(2'd0, 2, "R4 nak while pending");
    #1 chk("R11 nak no wen", buf_wen, 0);
    cpu_wr(8'h03); #1 chk("R3 write one keeps", reg_rdata, 8'h03);
    cpu_wr(8'h01); #1 chk("R7 cpu clears valid", reg_rdata, 8'h01);
    tok(2'd0, 2, "R4 done only nak");
    cpu_wr(8'h02); #1 chk("R3 clear done R7 one ignored", reg_rdata, 8'h00);
    tok(2'd0, 1, "R7 ack again");
    fin(1'b0);
    #1 chk("R12 bad out no change", reg_rdata, 8'h00);
    tok(2'd0, 1, "R7 ack third");
    fin(1'b1);
    cpu_wr(8'h02); #1 chk("R7 valid stays", reg_rdata, 8'h02);
    tok(2'd0, 2, "R7 valid naks");
    cpu_wr(8'h00);
    tok(2'd2, 1, "R9 setup is out");
    fin(1'b0);
    #1 chk("R12 setup bad", reg_rdata, 8'h00);
  endtask

  task automatic t_in_flow;
    cpu_wr(8'h10);
    tok(2'd1, 2, "R5 unarmed nak");
    cpu_wr(8'h12); #1 chk("R5 armed", reg_rdata, 8'h12);
    tok(2'd1, 1, "R5 armed ack");
    #1 chk("R11 in no wen", buf_wen, 0);
    fin(1'b1);
    #1 chk("R6 disarm", reg_rdata, 8'h11);
    tok(2'd1, 2, "R4 in done nak");
    cpu_wr(8'h12);
    tok(2'd1, 1, "R5 rearm ack");
    fin(1'b0);
    #1 chk("R12 bad in keeps", reg_rdata, 8'h12);
  endtask

  task automatic t_mismatch;
    tok(2'd0, 0, "R9 out on in ep");
    #1 chk("R9 no change", reg_rdata, 8'h12);
    chk("R9 no wen", buf_wen, 0);
    tok(2'd3, 0, "R9 pid3 ignored");
  endtask

  task automatic t_stall;
    cpu_wr(8'h32);
    tok(2'd1, 3, "R8 in stall");
    #1 chk("R8 status kept", reg_rdata, 8'h32);
    cpu_wr(8'h20);
    tok(2'd0, 3, "R8 out stall");
    #1 chk("R11 stall no wen", buf_wen, 0);
    chk("R8 status kept out", reg_rdata, 8'h20);
  endtask

  task automatic t_collide;
    cpu_wr(8'h00);
    tok(2'd0, 1, "R10 ack");
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = 8'h00; xfer_done = 1'b1; pkt_good = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; xfer_done = 1'b0; pkt_good = 1'b0;
    #1 chk("R10 hw wins", reg_rdata, 8'h03);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_config();
    t_out_flow();
    t_in_flow();
    t_mismatch();
    t_stall();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule